// File: doc/BRIEF.md
# Snooping MSI Line Coherence Controller

This block is the coherence engine for a small private, direct-mapped, write-back cache that shares a snooping bus with its peers. Every line holds a tag, one data word and one of three states: Invalid, Shared or Modified. Two sources drive it. The local processor issues reads and writes. The bus delivers the transactions of other caches, which are snooped.

A processor access that has the permission it needs completes in the cycle it is accepted. Any other access raises a bus request. Once granted, the controller first writes back a dirty victim if one occupies the index. It then places a read miss, a write miss or an invalidate on the bus, and waits for the fill when one is due. The processor side stays stalled until this sequence is finished.

On the snoop side, a matching Modified line intervenes. It supplies its data in place of memory, writes the line back, and then drops to Shared or Invalid. A matching Shared line is invalidated by any peer that wants to write. A snoop takes precedence over the processor in the cycle it arrives.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid: `cpu_ready` is high, `bus_req`, `snp_flush` and `mem_wr_valid` are low, and the first access to any address needs the bus.
- R2: A read whose tag matches a Shared or Modified line returns the stored word with `cpu_resp_valid` in its acceptance cycle, with no bus request.
- R3: A read miss raises `bus_req`. Only while `bus_gnt` is high does the controller drive `bus_cmd`=1 (read miss) with the request address for one cycle. Command codes: 0 none, 1 read miss, 2 write miss, 3 invalidate. It then waits for `fill_valid`, returns `fill_data` and installs the line as Shared.
- R4: A write miss issues `bus_cmd`=2, waits for the fill and installs the line as Modified holding the write data. A later read of that address hits and returns that data.
- R5: A write that hits a Shared line waits for the grant and issues `bus_cmd`=3 for one cycle with no fill. The write completes in that cycle and the line becomes Modified.
- R6: A write that hits a Modified line completes in its acceptance cycle with no bus activity.
- R7: On a miss whose index holds a Modified line with another tag, the victim word is written to `mem_wr_*` at the victim's address in the cycle before the miss command. A Shared victim is dropped without a write-back.
- R8: A snooped read miss (`snp_cmd`=1) that matches a Modified line raises `snp_flush` with the line's word on `snp_data` one cycle later. The same word goes out on `mem_wr_*`, and the line becomes Shared.
- R9: A snooped write miss (`snp_cmd`=2) that matches a Modified line flushes and writes back the same way, and the line becomes Invalid.
- R10: A snooped invalidate (`snp_cmd`=3) or write miss that matches a Shared line makes it Invalid, without a flush.
- R11: A snoop whose address does not match a valid line changes nothing: no flush, no write-back, and the line keeps its state.
- R12: While `snp_valid` is high, `cpu_ready` is low and no processor request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | AW | Word address of the request |
| cpu_req_wdata | input | DW | Write data |
| cpu_ready | output | 1 | Request accepted when high together with valid |
| cpu_resp_valid | output | 1 | Request completes this cycle |
| cpu_rdata | output | DW | Read data for a completing read |
| bus_req | output | 1 | Bus request, held until the transaction ends |
| bus_gnt | input | 1 | Bus grant |
| bus_cmd | output | 2 | Issued command: 0 none, 1 read miss, 2 write miss, 3 invalidate |
| bus_addr | output | AW | Address of the issued command |
| fill_valid | input | 1 | Fill word for the outstanding miss |
| fill_data | input | DW | Fill word |
| snp_valid | input | 1 | Snooped peer transaction present (only while not granted) |
| snp_cmd | input | 2 | Snooped command, same codes as `bus_cmd` |
| snp_addr | input | AW | Snooped address |
| snp_flush | output | 1 | This cache supplies the data and cancels the memory reply |
| snp_data | output | DW | Supplied word |
| mem_wr_valid | output | 1 | Write-back to memory |
| mem_wr_addr | output | AW | Write-back address |
| mem_wr_data | output | DW | Write-back word |

## Verification
The bench builds the controller with an 8-bit address, 16-bit words and four lines, so the index is the low two address bits. Several addresses that share an index are therefore easy to pick, and they reach Modified and Shared victims within a few accesses. The bench's grant comes two cycles after the request, which leaves the request-wait state visible. Fills arrive two cycles after the command. Snoops are aimed both at resident tags and at aliasing tags on the same index.

// File: rtl/msi_pkg.sv
package msi_pkg;

  typedef enum logic [1:0] {
    LS_I = 2'd0,
    LS_S = 2'd1,
    LS_M = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    BC_NONE   = 2'd0,
    BC_RDMISS = 2'd1,
    BC_WRMISS = 2'd2,
    BC_INV    = 2'd3
  } bus_cmd_e;

  // Does the current state already allow this access without the bus?
  function automatic logic perm_ok(line_st_e st, logic wr);
    return wr ? (st == LS_M) : (st != LS_I);
  endfunction

  // State after a matching snoop
  function automatic line_st_e snoop_next(bus_cmd_e c, line_st_e st);
    case (c)
      BC_RDMISS: return (st == LS_M) ? LS_S : st;
      BC_WRMISS,
      BC_INV:    return LS_I;
      default:   return st;
    endcase
  endfunction

  // Does a matching snoop force intervention plus write-back?
  function automatic logic snoop_flush(bus_cmd_e c, line_st_e st);
    return (st == LS_M) && ((c == BC_RDMISS) || (c == BC_WRMISS));
  endfunction

endpackage

// File: rtl/msi_line_array.sv
module msi_line_array
  import msi_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int TAG_W = 6,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] cpu_idx,
  input  logic             cpu_we,
  input  line_st_e         cpu_st,
  input  logic [TAG_W-1:0] cpu_tag,
  input  logic             cpu_data_we,
  input  logic [DW-1:0]    cpu_data,
  input  logic [IDX_W-1:0] snp_idx,
  input  logic             snp_we,
  input  line_st_e         snp_st,
  output line_st_e         cpu_st_o,
  output logic [TAG_W-1:0] cpu_tag_o,
  output logic [DW-1:0]    cpu_data_o,
  output line_st_e         snp_st_o,
  output logic [TAG_W-1:0] snp_tag_o,
  output logic [DW-1:0]    snp_data_o
);
  localparam int NLINES = 1 << IDX_W;

  logic [NLINES-1:0][1:0]       st_all;
  logic [NLINES-1:0][TAG_W-1:0] tag_all;
  logic [NLINES-1:0][DW-1:0]    dat_all;

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    line_st_e         st_q;
    logic [TAG_W-1:0] tag_q;
    logic [DW-1:0]    dat_q;

    // snoop updates win; the protocol keeps both ports from colliding
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q  <= LS_I;
        tag_q <= '0;
        dat_q <= '0;
      end else if (snp_we && (snp_idx == IDX_W'(i))) begin
        st_q <= snp_st;
      end else if (cpu_we && (cpu_idx == IDX_W'(i))) begin
        st_q  <= cpu_st;
        tag_q <= cpu_tag;
        if (cpu_data_we) dat_q <= cpu_data;
      end
    end

    assign st_all[i]  = st_q;
    assign tag_all[i] = tag_q;
    assign dat_all[i] = dat_q;
  end

  assign cpu_st_o   = line_st_e'(st_all[cpu_idx]);
  assign cpu_tag_o  = tag_all[cpu_idx];
  assign cpu_data_o = dat_all[cpu_idx];
  assign snp_st_o   = line_st_e'(st_all[snp_idx]);
  assign snp_tag_o  = tag_all[snp_idx];
  assign snp_data_o = dat_all[snp_idx];

endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
  import msi_pkg::*;
#(
  parameter int AW    = 8,
  parameter int IDX_W = 2,
  parameter int DW    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                snp_valid,
  input  logic [1:0]          snp_cmd,
  input  logic [AW-1:0]       snp_addr,
  input  line_st_e            line_st,
  input  logic [AW-IDX_W-1:0] line_tag,
  input  logic [DW-1:0]       line_data,
  output logic [IDX_W-1:0]    snp_idx,
  output logic                snp_we,
  output line_st_e            snp_st,
  output logic                flush_q,
  output logic [AW-1:0]       flush_addr_q,
  output logic [DW-1:0]       flush_data_q
);
  localparam int TAG_W = AW - IDX_W;

  bus_cmd_e         cmd;
  logic [TAG_W-1:0] s_tag;
  logic             snp_match;
  logic             flush_ev;

  assign cmd       = bus_cmd_e'(snp_cmd);
  assign snp_idx   = snp_addr[IDX_W-1:0];
  assign s_tag     = snp_addr[AW-1:IDX_W];
  assign snp_match = snp_valid && (line_st != LS_I) && (line_tag == s_tag);
  assign snp_st    = snoop_next(cmd, line_st);
  assign snp_we    = snp_match && (snp_st != line_st);
  assign flush_ev  = snp_match && snoop_flush(cmd, line_st);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flush_q      <= 1'b0;
      flush_addr_q <= '0;
      flush_data_q <= '0;
    end else begin
      flush_q      <= flush_ev;
      flush_addr_q <= snp_addr;
      flush_data_q <= line_data;
    end
  end

  // R11
  nomatch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && !snp_match) |=> !flush_q);

  // R8
  flush_from_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |-> $past(snp_valid));

endmodule

// File: rtl/msi_cpu_fsm.sv
module msi_cpu_fsm
  import msi_pkg::*;
#(
  parameter int AW    = 8,
  parameter int IDX_W = 2,
  parameter int DW    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_req_valid,
  input  logic                cpu_req_write,
  input  logic [AW-1:0]       cpu_req_addr,
  input  logic [DW-1:0]       cpu_req_wdata,
  output logic                cpu_ready,
  output logic                cpu_resp_valid,
  output logic [DW-1:0]       cpu_rdata,
  output logic                bus_req,
  input  logic                bus_gnt,
  output logic [1:0]          bus_cmd,
  output logic [AW-1:0]       bus_addr,
  input  logic                fill_valid,
  input  logic [DW-1:0]       fill_data,
  input  logic                snp_valid,
  output logic [IDX_W-1:0]    lk_idx,
  input  line_st_e            line_st,
  input  logic [AW-IDX_W-1:0] line_tag,
  input  logic [DW-1:0]       line_data,
  output logic                arr_we,
  output line_st_e            arr_st,
  output logic [AW-IDX_W-1:0] arr_tag,
  output logic                arr_data_we,
  output logic [DW-1:0]       arr_data,
  output logic                victim_wb,
  output logic [AW-1:0]       victim_addr,
  output logic [DW-1:0]       victim_data
);
  localparam int TAG_W = AW - IDX_W;

  typedef enum logic [1:0] {FS_IDLE, FS_ARB, FS_ISSUE, FS_FILL} fsm_e;

  fsm_e             state_q, state_d;
  logic             rq_write;
  logic [AW-1:0]    rq_addr;
  logic [DW-1:0]    rq_wdata;

  logic             cur_write;
  logic [AW-1:0]    cur_addr;
  logic [DW-1:0]    cur_wdata;
  logic [TAG_W-1:0] lk_tag;
  logic             lk_hit;
  logic             lk_ok;
  logic             accept;
  bus_cmd_e         cmd;

  assign cur_write = (state_q == FS_IDLE) ? cpu_req_write : rq_write;
  assign cur_addr  = (state_q == FS_IDLE) ? cpu_req_addr  : rq_addr;
  assign cur_wdata = (state_q == FS_IDLE) ? cpu_req_wdata : rq_wdata;
  assign lk_idx    = cur_addr[IDX_W-1:0];
  assign lk_tag    = cur_addr[AW-1:IDX_W];
  assign lk_hit    = (line_st != LS_I) && (line_tag == lk_tag);
  assign lk_ok     = lk_hit && perm_ok(line_st, cur_write);
  assign accept    = (state_q == FS_IDLE) && cpu_req_valid && !snp_valid;

  always_comb begin
    state_d        = state_q;
    cpu_ready      = 1'b0;
    cpu_resp_valid = 1'b0;
    cpu_rdata      = line_data;
    bus_req        = 1'b0;
    cmd            = BC_NONE;
    bus_addr       = cur_addr;
    arr_we         = 1'b0;
    arr_st         = line_st;
    arr_tag        = lk_tag;
    arr_data_we    = 1'b0;
    arr_data       = cur_wdata;
    victim_wb      = 1'b0;
    victim_addr    = {line_tag, lk_idx};
    victim_data    = line_data;
    case (state_q)
      FS_IDLE: begin
        cpu_ready = !snp_valid;
        if (accept) begin
          if (lk_ok) begin
            cpu_resp_valid = 1'b1;
            if (cur_write) begin
              arr_we      = 1'b1;
              arr_st      = LS_M;
              arr_data_we = 1'b1;
            end
          end else begin
            state_d = FS_ARB;
          end
        end
      end
      FS_ARB: begin
        bus_req = 1'b1;
        if (bus_gnt) state_d = FS_ISSUE;
      end
      FS_ISSUE: begin
        bus_req = 1'b1;
        if ((line_st == LS_M) && !lk_hit) begin
          victim_wb = 1'b1;
          arr_we    = 1'b1;
          arr_st    = LS_I;
          arr_tag   = line_tag;
        end else if (lk_ok) begin
          cpu_resp_valid = 1'b1;
          state_d        = FS_IDLE;
        end else if (lk_hit && cur_write) begin
          cmd            = BC_INV;
          arr_we         = 1'b1;
          arr_st         = LS_M;
          arr_data_we    = 1'b1;
          cpu_resp_valid = 1'b1;
          state_d        = FS_IDLE;
        end else begin
          cmd     = cur_write ? BC_WRMISS : BC_RDMISS;
          state_d = FS_FILL;
        end
      end
      FS_FILL: begin
        bus_req = 1'b1;
        if (fill_valid) begin
          arr_we         = 1'b1;
          arr_st         = cur_write ? LS_M : LS_S;
          arr_data_we    = 1'b1;
          arr_data       = cur_write ? cur_wdata : fill_data;
          cpu_resp_valid = 1'b1;
          cpu_rdata      = fill_data;
          state_d        = FS_IDLE;
        end
      end
      default: state_d = FS_IDLE;
    endcase
  end

  assign bus_cmd = cmd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= FS_IDLE;
      rq_write <= 1'b0;
      rq_addr  <= '0;
      rq_wdata <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        rq_write <= cpu_req_write;
        rq_addr  <= cpu_req_addr;
        rq_wdata <= cpu_req_wdata;
      end
    end
  end

  // R3
  granted_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == FS_ISSUE) || (state_q == FS_FILL)) |-> bus_gnt);

  // R5
  upgrade_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == BC_INV) |=> (state_q == FS_IDLE) && !bus_req);

  // R7
  wb_before_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    victim_wb |=> ((bus_cmd == BC_RDMISS) || (bus_cmd == BC_WRMISS)));

  // R12
  snoop_blocks_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !cpu_ready);

  // R2
  hit_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == FS_IDLE) && cpu_resp_valid) |-> !bus_req);

endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
  import msi_pkg::*;
#(
  parameter int AW    = 8,
  parameter int IDX_W = 2,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req_valid,
  input  logic          cpu_req_write,
  input  logic [AW-1:0] cpu_req_addr,
  input  logic [DW-1:0] cpu_req_wdata,
  output logic          cpu_ready,
  output logic          cpu_resp_valid,
  output logic [DW-1:0] cpu_rdata,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [1:0]    bus_cmd,
  output logic [AW-1:0] bus_addr,
  input  logic          fill_valid,
  input  logic [DW-1:0] fill_data,
  input  logic          snp_valid,
  input  logic [1:0]    snp_cmd,
  input  logic [AW-1:0] snp_addr,
  output logic          snp_flush,
  output logic [DW-1:0] snp_data,
  output logic          mem_wr_valid,
  output logic [AW-1:0] mem_wr_addr,
  output logic [DW-1:0] mem_wr_data
);
  localparam int TAG_W = AW - IDX_W;

  logic [IDX_W-1:0] c_idx, s_idx;
  line_st_e         c_st, s_st, a_st, sn_st;
  logic [TAG_W-1:0] c_tag, s_tag, a_tag;
  logic [DW-1:0]    c_data, s_data, a_data;
  logic             a_we, a_data_we, sn_we;
  logic             victim_wb, flush_q;
  logic [AW-1:0]    victim_addr, flush_addr;
  logic [DW-1:0]    victim_data, flush_data;

  msi_line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DW(DW)) u_array (
    .clk(clk), .rst_n(rst_n),
    .cpu_idx(c_idx), .cpu_we(a_we), .cpu_st(a_st), .cpu_tag(a_tag),
    .cpu_data_we(a_data_we), .cpu_data(a_data),
    .snp_idx(s_idx), .snp_we(sn_we), .snp_st(sn_st),
    .cpu_st_o(c_st), .cpu_tag_o(c_tag), .cpu_data_o(c_data),
    .snp_st_o(s_st), .snp_tag_o(s_tag), .snp_data_o(s_data)
  );

  msi_snoop_unit #(.AW(AW), .IDX_W(IDX_W), .DW(DW)) u_snoop (
    .clk(clk), .rst_n(rst_n),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .line_st(s_st), .line_tag(s_tag), .line_data(s_data),
    .snp_idx(s_idx), .snp_we(sn_we), .snp_st(sn_st),
    .flush_q(flush_q), .flush_addr_q(flush_addr), .flush_data_q(flush_data)
  );

  msi_cpu_fsm #(.AW(AW), .IDX_W(IDX_W), .DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_ready(cpu_ready), .cpu_resp_valid(cpu_resp_valid), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .fill_valid(fill_valid), .fill_data(fill_data), .snp_valid(snp_valid),
    .lk_idx(c_idx), .line_st(c_st), .line_tag(c_tag), .line_data(c_data),
    .arr_we(a_we), .arr_st(a_st), .arr_tag(a_tag),
    .arr_data_we(a_data_we), .arr_data(a_data),
    .victim_wb(victim_wb), .victim_addr(victim_addr), .victim_data(victim_data)
  );

  assign snp_flush    = flush_q;
  assign snp_data     = flush_data;
  assign mem_wr_valid = victim_wb | flush_q;
  assign mem_wr_addr  = victim_wb ? victim_addr : flush_addr;
  assign mem_wr_data  = victim_wb ? victim_data : flush_data;

  // R8
  wr_port_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(victim_wb && flush_q));

  // R3
  cmd_needs_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd != 2'd0) |-> (bus_gnt && bus_req));

endmodule

// File: tb/msi_snoop_ctrl_tb_top.sv
module msi_snoop_ctrl_tb_top;
  localparam int AW = 8, IDX_W = 2, DW = 16;
  localparam int CLK_PER = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
  logic [AW-1:0] cpu_req_addr = '0;
  logic [DW-1:0] cpu_req_wdata = '0;
  logic cpu_ready, cpu_resp_valid, bus_req, snp_flush, mem_wr_valid;
  logic [DW-1:0] cpu_rdata, snp_data, mem_wr_data;
  logic bus_gnt = 1'b0, fill_valid = 1'b0, snp_valid = 1'b0;
  logic [DW-1:0] fill_data = '0;
  logic [1:0] bus_cmd, snp_cmd = 2'd0;
  logic [AW-1:0] bus_addr, mem_wr_addr, snp_addr = '0;

  msi_snoop_ctrl #(.AW(AW), .IDX_W(IDX_W), .DW(DW)) dut_i (.*);

  initial forever #(CLK_PER/2) clk = ~clk;

  typedef struct { int kind; logic [AW-1:0] addr; logic [DW-1:0] data; string req; } ev_t;
  typedef struct { bit chk; logic [DW-1:0] data; string req; } rsp_t;
  ev_t  exp_ev[$];
  rsp_t exp_rsp[$];
  int checks = 0, errors = 0, cycles = 0;
  logic [DW-1:0] mem [1 << AW];

  function automatic logic [DW-1:0] init_val(int a);
    return DW'(a * 3 + 16'h100);
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // bus environment and monitor: drive at negedge+2, sample at negedge+3
  initial begin
    int req_cnt = 0, fill_cnt = 0;
    logic [AW-1:0] fill_addr = '0;
    for (int i = 0; i < (1 << AW); i++) mem[i] = init_val(i);
    forever begin
      @(negedge clk);
      #2;
      bus_gnt = bus_req && (req_cnt >= 2);
      if (fill_cnt == 1) begin
        fill_valid = 1'b1;
        fill_data  = mem[fill_addr];
      end else begin
        fill_valid = 1'b0;
      end
      if (fill_cnt > 0) fill_cnt--;
      #1;
      cycles++;
      if (cycles > 100000) begin
        check(0, "WDOG", "watchdog expired", cycles, 100000);
        finish_run();
      end
      req_cnt = bus_req ? req_cnt + 1 : 0;
      if (mem_wr_valid) begin
        ev_t e;
        mem[mem_wr_addr] = mem_wr_data;
        if (exp_ev.size() == 0) check(0, "SEQ", "unexpected write-back", {24'd0, mem_wr_addr}, 0);
        else begin
          e = exp_ev.pop_front();
          check(e.kind == 4 && e.addr == mem_wr_addr && e.data == mem_wr_data, e.req,
                "write-back kind/addr/data", {4'd4, 4'd0, mem_wr_addr, mem_wr_data},
                {e.kind[3:0], 4'd0, e.addr, e.data});
        end
      end
      if (bus_cmd != 2'd0) begin
        ev_t e;
        if (bus_cmd != 2'd3) begin
          fill_cnt  = 2;
          fill_addr = bus_addr;
        end
        if (exp_ev.size() == 0) check(0, "SEQ", "unexpected bus command", {22'd0, bus_cmd, bus_addr}, 0);
        else begin
          e = exp_ev.pop_front();
          check(e.kind == int'(bus_cmd) && e.addr == bus_addr, e.req, "bus cmd/addr",
                {22'd0, bus_cmd, bus_addr}, {22'd0, e.kind[1:0], e.addr});
        end
      end
      if (cpu_resp_valid) begin
        rsp_t r;
        if (exp_rsp.size() == 0) check(0, "SEQ", "unexpected response", {16'd0, cpu_rdata}, 0);
        else begin
          r = exp_rsp.pop_front();
          if (r.chk) check(cpu_rdata == r.data, r.req, "read data", {16'd0, cpu_rdata}, {16'd0, r.data});
        end
      end
    end
  end

  task automatic expect_ev(int kind, int addr, logic [DW-1:0] data, string req);
    ev_t e;
    e.kind = kind; e.addr = AW'(addr); e.data = data; e.req = req;
    exp_ev.push_back(e);
  endtask

  task automatic cpu_op(bit wr, int addr, logic [DW-1:0] data, string req);
    rsp_t r;
    r.chk = !wr; r.data = data; r.req = req;
    exp_rsp.push_back(r);
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = AW'(addr);
    cpu_req_wdata = wr ? data : '0;
    #1;
    while (!cpu_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    while (exp_rsp.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(exp_ev.size() == 0, req, "missing bus events", exp_ev.size(), 0);
  endtask

  task automatic snoop(int cmd, int addr, bit exp_flush, logic [DW-1:0] exp_data, string req);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = 2'(cmd); snp_addr = AW'(addr);
    #1;
    check(cpu_ready == 1'b0, "R12", "ready during snoop", cpu_ready, 0);
    @(negedge clk);
    snp_valid = 1'b0;
    #1;
    check(snp_flush == exp_flush, req, "flush", snp_flush, exp_flush);
    if (exp_flush) check(snp_data == exp_data, req, "supplied data", {16'd0, snp_data}, {16'd0, exp_data});
    repeat (3) @(negedge clk);
    check(exp_ev.size() == 0, req, "missing write-back", exp_ev.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1: reset state
    check(cpu_ready == 1'b1, "R1", "ready after reset", cpu_ready, 1);
    check(bus_req == 1'b0 && snp_flush == 1'b0 && mem_wr_valid == 1'b0, "R1", "quiet after reset",
          {bus_req, snp_flush, mem_wr_valid}, 0);

    // R1 / R3: cold read misses, installs Shared
    expect_ev(1, 4, 0, "R3");
    cpu_op(0, 4, init_val(4), "R3");
    // R2: read hit on Shared
    cpu_op(0, 4, init_val(4), "R2");
    // R5: write hit on Shared upgrades with invalidate
    expect_ev(3, 4, 0, "R5");
    cpu_op(1, 4, 16'hAAAA, "R5");
    cpu_op(0, 4, 16'hAAAA, "R2");
    // R6: write hit on Modified stays local
    cpu_op(1, 4, 16'hBBBB, "R6");
    cpu_op(0, 4, 16'hBBBB, "R6");
    // R4: write miss installs Modified
    expect_ev(2, 9, 0, "R4");
    cpu_op(1, 9, 16'h1234, "R4");
    cpu_op(0, 9, 16'h1234, "R4");
    // R7: Modified victim written back before the miss
    expect_ev(4, 4, 16'hBBBB, "R7");
    expect_ev(1, 8, 0, "R7");
    cpu_op(0, 8, init_val(8), "R7");
    // R7: Shared victim dropped silently
    expect_ev(1, 12, 0, "R7");
    cpu_op(0, 12, init_val(12), "R7");
    expect_ev(1, 4, 0, "R7");
    cpu_op(0, 4, 16'hBBBB, "R7");
    // R8: snooped read miss on Modified -> flush, write-back, Shared
    expect_ev(4, 9, 16'h1234, "R8");
    snoop(1, 9, 1, 16'h1234, "R8");
    expect_ev(3, 9, 0, "R8");
    cpu_op(1, 9, 16'h5555, "R8");
    // R9: snooped write miss on Modified -> flush, write-back, Invalid
    expect_ev(4, 9, 16'h5555, "R9");
    snoop(2, 9, 1, 16'h5555, "R9");
    expect_ev(1, 9, 0, "R9");
    cpu_op(0, 9, 16'h5555, "R9");
    // R10: invalidate and write miss on Shared -> Invalid
    snoop(3, 4, 0, 0, "R10");
    expect_ev(1, 4, 0, "R10");
    cpu_op(0, 4, 16'hBBBB, "R10");
    snoop(2, 9, 0, 0, "R10");
    expect_ev(1, 9, 0, "R10");
    cpu_op(0, 9, 16'h5555, "R10");
    // R11: non-matching snoops leave the line alone
    expect_ev(2, 10, 0, "R11");
    cpu_op(1, 10, 16'h7777, "R11");
    snoop(1, 14, 0, 0, "R11");
    snoop(3, 3, 0, 0, "R11");
    cpu_op(1, 10, 16'h8888, "R11");
    cpu_op(0, 10, 16'h8888, "R11");

    finish_run();
  end

endmodule